// File: doc/BRIEF.md
# Accumulating Adder with Overflow Counter

This block is the 32-bit add unit that sits next to a register file holding a product register P and an accumulator ACC. Each cycle it can take one decoded operation strobe together with an operand from the memory-read port. It then either adds the operand unsigned into P, adds the operand plus the current carry flag into ACC, or loads one of the two registers directly. The register values, the flags N, Z, C and V, a 6-bit overflow counter and a repeat count are all registered, and each result shows on the outputs one clock after the strobe.

A 64-bit sum across ACC:P takes two operations in a row. The first adds the low word unsigned into P, which leaves the carry in C. The second adds the high word with carry into ACC. The overflow counter counts carries out of the unsigned add whatever the saturation setting is. V is sticky. The unsigned add cannot be repeated: issuing it discards any pending repeat count, so the add runs once.

Top module: `wide_add_unit`

## Requirements
- R1: With `op_valid` high and `op_sel` = 2'b00 (unsigned add), P becomes (P + `operand`) mod 2^32 after the next clock edge, and ACC is unchanged.
- R2: With `op_sel` = 2'b01 (add with carry), ACC becomes ACC + `operand` + C mod 2^32 and P is unchanged. An unsigned add of the low words followed by this operation on the high words leaves the 64-bit sum in {ACC, P}.
- R3: After either add, N equals bit 31 of the register just written. Z is 1 exactly when that register is zero.
- R4: After either add, C is the carry out of bit 31 of the 32-bit addition, and is cleared when there is no carry.
- R5: An add sets V when both addends have the same sign bit and the result's sign bit differs. Otherwise V keeps its value, and only reset clears it.
- R6: The 6-bit overflow counter increments, wrapping modulo 64, on each unsigned add that produces a carry. All other operations leave it unchanged.
- R7: `sat_mode` has no effect on the unsigned add (result, flags and counter). With `sat_mode` high, an add with carry that overflows writes 0x7FFFFFFF to ACC when the addends were non-negative and 0x80000000 when they were negative. N and Z follow the saturated value, while C and V follow the raw addition.
- R8: `rpt_set` loads `rpt_value` into the repeat count. An unsigned add clears the repeat count to zero, and this takes priority over `rpt_set` in the same cycle. The add still updates P exactly once.
- R9: `op_sel` = 2'b10 loads `operand` into P and 2'b11 loads it into ACC. Neither changes the flags or the overflow counter.
- R10: With `op_valid` low, P, ACC, the flags and the overflow counter hold their values.
- R11: Synchronous active-high reset clears P, ACC, all four flags, the overflow counter and the repeat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Decoded operation strobe |
| op_sel | input | 2 | 00 unsigned add to P, 01 add with carry to ACC, 10 load P, 11 load ACC |
| operand | input | 32 | Operand from the memory-read port |
| sat_mode | input | 1 | Saturation enable for the add with carry |
| rpt_set | input | 1 | Load the repeat count |
| rpt_value | input | 8 | Repeat count to load |
| p_out | output | 32 | Product register P |
| acc_out | output | 32 | Accumulator ACC |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Sticky overflow flag |
| ovc_out | output | 6 | Unsigned-carry overflow counter |
| rpt_out | output | 8 | Pending repeat count |

## Verification
The bench targets the boundaries of the add: a sum that wraps to exactly zero, which needs Z, C and V set together; a signed overflow followed by a clean add, which a design that recomputes V each time would clear; and sixty-four carries in a row, which a design with the wrong counter width or a missing wrap would miscount. The bench also runs unsigned adds with saturation on. A design that let the mode reach P or the counter would clamp the sum or skip counts. It issues an unsigned add in the same cycle as a repeat-count load, which a design with the wrong priority would leave non-zero. A 64-bit chained sum confirms that the carry passes from the low add into the high add.

// File: rtl/wau_pkg.sv
package wau_pkg;
  typedef enum logic [1:0] {
    OP_ADDU  = 2'b00,
    OP_ADDC  = 2'b01,
    OP_LDP   = 2'b10,
    OP_LDACC = 2'b11
  } wau_op_e;
endpackage

// File: rtl/wau_adder.sv
module wau_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  localparam int MSB = W - 1;
  logic [W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[W];
    // signed overflow: equal input signs, differing result sign
    ovf  = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
  end
endmodule

// File: rtl/wau_flag_eval.sv
module wau_flag_eval #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  output logic         neg,
  output logic         zero
);
  assign neg  = value[W-1];
  assign zero = (value == '0);
endmodule

// File: rtl/wau_ovc_ctr.sv
module wau_ovc_ctr #(
  parameter int OVC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [OVC_W-1:0] count
);
  localparam logic [OVC_W-1:0] ONE = OVC_W'(1);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + ONE; // wraps modulo 2**OVC_W
  end
endmodule

// File: rtl/wau_rpt_ctr.sv
module wau_rpt_ctr #(
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set,
  input  logic [RPT_W-1:0] val,
  output logic [RPT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (clr) cnt <= '0;   // non-repeatable add wins
    else if (set) cnt <= val;
  end
endmodule

// File: rtl/wide_add_unit.sv
module wide_add_unit
  import wau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OVC_W  = 6,
  parameter int RPT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] operand,
  input  logic              sat_mode,
  input  logic              rpt_set,
  input  logic [RPT_W-1:0]  rpt_value,
  output logic [DATA_W-1:0] p_out,
  output logic [DATA_W-1:0] acc_out,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic [OVC_W-1:0]  ovc_out,
  output logic [RPT_W-1:0]  rpt_out
);
  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] SAT_MAX = {1'b0, {MSB{1'b1}}};
  localparam logic [DATA_W-1:0] SAT_MIN = {1'b1, {MSB{1'b0}}};

  wau_op_e op;
  logic is_addu, is_addc, is_ldp, is_ldacc, is_add;
  logic [DATA_W-1:0] p_q, acc_q, add_a, raw_sum, res;
  logic n_q, z_q, c_q, v_q;
  logic cin, cout, ovf, res_neg, res_zero;

  assign op       = wau_op_e'(op_sel);
  assign is_addu  = op_valid && (op == OP_ADDU);
  assign is_addc  = op_valid && (op == OP_ADDC);
  assign is_ldp   = op_valid && (op == OP_LDP);
  assign is_ldacc = op_valid && (op == OP_LDACC);
  assign is_add   = is_addu || is_addc;

  assign add_a = is_addc ? acc_q : p_q;
  assign cin   = is_addc & c_q;

  wau_adder #(.W(DATA_W)) u_adder (
    .a(add_a), .b(operand), .cin(cin),
    .sum(raw_sum), .cout(cout), .ovf(ovf)
  );

  // saturation applies only to the accumulator path
  always_comb begin
    res = raw_sum;
    if (is_addc && sat_mode && ovf)
      res = add_a[MSB] ? SAT_MIN : SAT_MAX;
  end

  wau_flag_eval #(.W(DATA_W)) u_flags (
    .value(res), .neg(res_neg), .zero(res_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q   <= '0;
      acc_q <= '0;
      n_q   <= 1'b0;
      z_q   <= 1'b0;
      c_q   <= 1'b0;
      v_q   <= 1'b0;
    end else begin
      if (is_addu)  p_q   <= res;
      if (is_addc)  acc_q <= res;
      if (is_ldp)   p_q   <= operand;
      if (is_ldacc) acc_q <= operand;
      if (is_add) begin
        n_q <= res_neg;
        z_q <= res_zero;
        c_q <= cout;
        if (ovf) v_q <= 1'b1;
      end
    end
  end

  wau_ovc_ctr #(.OVC_W(OVC_W)) u_ovc (
    .clk(clk), .rst(rst), .inc(is_addu && cout), .count(ovc_out)
  );

  wau_rpt_ctr #(.RPT_W(RPT_W)) u_rpt (
    .clk(clk), .rst(rst), .clr(is_addu), .set(rpt_set),
    .val(rpt_value), .cnt(rpt_out)
  );

  assign p_out   = p_q;
  assign acc_out = acc_q;
  assign flag_n  = n_q;
  assign flag_z  = z_q;
  assign flag_c  = c_q;
  assign flag_v  = v_q;
endmodule

// File: rtl/wau_checker.sv
module wau_checker #(
  parameter int DATA_W = 32,
  parameter int OVC_W  = 6,
  parameter int RPT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [1:0]        op_sel,
  input logic [DATA_W-1:0] operand,
  input logic [DATA_W-1:0] p_out,
  input logic [DATA_W-1:0] acc_out,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v,
  input logic [OVC_W-1:0]  ovc_out,
  input logic [RPT_W-1:0]  rpt_out
);
  logic [DATA_W:0] p_wide;
  logic addu_now, addc_now, add_now, load_now, addu_cy;

  assign p_wide   = {1'b0, p_out} + {1'b0, operand};
  assign addu_cy  = p_wide[DATA_W];
  assign addu_now = op_valid && (op_sel == 2'b00);
  assign addc_now = op_valid && (op_sel == 2'b01);
  assign add_now  = op_valid && !op_sel[1];
  assign load_now = op_valid && op_sel[1];

  // R1 (holds whatever sat_mode is, R7)
  addu_sum_chk: assert property (@(posedge clk) disable iff (rst)
    addu_now |=> (p_out == $past(p_out + operand)) && $stable(acc_out));

  // R2
  addc_keep_p_chk: assert property (@(posedge clk) disable iff (rst)
    addc_now |=> $stable(p_out));

  // R3
  neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    add_now |=> flag_n == ($past(op_sel[0]) ? acc_out[DATA_W-1] : p_out[DATA_W-1]));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    add_now |=> flag_z == ($past(op_sel[0]) ? (acc_out == '0) : (p_out == '0)));

  // R4
  addu_carry_chk: assert property (@(posedge clk) disable iff (rst)
    addu_now |=> flag_c == $past(addu_cy));

  // R5
  v_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_v |=> flag_v);

  // R6
  ovc_step_chk: assert property (@(posedge clk) disable iff (rst)
    addu_now |=> ovc_out == $past(ovc_out) + OVC_W'($past(addu_cy)));

  // R6
  ovc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !addu_now |=> $stable(ovc_out));

  // R8
  rpt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    addu_now |=> rpt_out == '0);

  // R9
  load_flags_chk: assert property (@(posedge clk) disable iff (rst)
    load_now |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(p_out) && $stable(acc_out)
                  && $stable({flag_n, flag_z, flag_c, flag_v}));
endmodule

bind wide_add_unit wau_checker #(
  .DATA_W(DATA_W), .OVC_W(OVC_W), .RPT_W(RPT_W)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
  .operand(operand), .p_out(p_out), .acc_out(acc_out),
  .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
  .ovc_out(ovc_out), .rpt_out(rpt_out)
);

// File: tb/wide_add_unit_tb.sv
module wide_add_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int OW = 6;
  localparam int RW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [DW-1:0] operand = '0;
  logic sat_mode = 1'b0;
  logic rpt_set = 1'b0;
  logic [RW-1:0] rpt_value = '0;
  logic [DW-1:0] p_out, acc_out;
  logic flag_n, flag_z, flag_c, flag_v;
  logic [OW-1:0] ovc_out;
  logic [RW-1:0] rpt_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [DW-1:0] m_p, m_acc;
  bit m_n, m_z, m_c, m_v;
  int m_ovc, m_rpt;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_add_unit #(.DATA_W(DW), .OVC_W(OW), .RPT_W(RW)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .operand(operand), .sat_mode(sat_mode), .rpt_set(rpt_set),
    .rpt_value(rpt_value), .p_out(p_out), .acc_out(acc_out),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .ovc_out(ovc_out), .rpt_out(rpt_out)
  );

  task automatic compare(input string tag);
    checks++;
    if (p_out !== m_p || acc_out !== m_acc ||
        {flag_n, flag_z, flag_c, flag_v} !== {m_n, m_z, m_c, m_v} ||
        int'(ovc_out) != m_ovc || int'(rpt_out) != m_rpt) begin
      errors++;
      $display("FAIL %s: got p=%h acc=%h nzcv=%b ovc=%0d rpt=%0d expected p=%h acc=%h nzcv=%b ovc=%0d rpt=%0d",
               tag, p_out, acc_out, {flag_n, flag_z, flag_c, flag_v}, ovc_out, rpt_out,
               m_p, m_acc, {m_n, m_z, m_c, m_v}, m_ovc, m_rpt);
    end
  endtask

  // behavioural update from the requirement text
  task automatic model_step();
    logic [DW:0] w;
    logic [DW-1:0] a, r;
    bit ov;
    if (op_valid && !op_sel[1]) begin
      a  = op_sel[0] ? m_acc : m_p;
      w  = {1'b0, a} + {1'b0, operand} + ((op_sel[0] && m_c) ? 33'd1 : 33'd0);
      r  = w[DW-1:0];
      ov = (a[DW-1] == operand[DW-1]) && (r[DW-1] != a[DW-1]);
      if (op_sel[0] && sat_mode && ov) r = a[DW-1] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      if (op_sel[0]) m_acc = r; else m_p = r;
      m_n = r[DW-1];
      m_z = (r == 0);
      m_c = w[DW];
      if (ov) m_v = 1;
      if (!op_sel[0] && w[DW]) m_ovc = (m_ovc + 1) % 64;
    end else if (op_valid) begin
      if (op_sel[0]) m_acc = operand; else m_p = operand;
    end
    if (op_valid && op_sel == 2'b00) m_rpt = 0;
    else if (rpt_set) m_rpt = int'(rpt_value);
  endtask

  task automatic cyc(input bit v, input logic [1:0] op, input logic [DW-1:0] d,
                     input bit sat, input bit rs, input logic [RW-1:0] rv,
                     input string tag);
    op_valid = v; op_sel = op; operand = d; sat_mode = sat;
    rpt_set = rs; rpt_value = rv;
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, y, s;
    int ovc_before;
    m_p = 0; m_acc = 0; m_n = 0; m_z = 0; m_c = 0; m_v = 0; m_ovc = 0; m_rpt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R11 reset state");

    // R9 load, R1/R4/R6 carry out of unsigned add
    cyc(1, 2'b10, 32'hFFFF_FFF0, 0, 0, 0, "R9 load P");
    cyc(1, 2'b00, 32'h0000_0020, 0, 0, 0, "R1 R4 R6 addu carry");
    cyc(1, 2'b11, 32'h0000_0005, 0, 0, 0, "R9 load ACC");
    cyc(1, 2'b01, 32'h0000_0007, 0, 0, 0, "R2 addc with C");
    // R5 overflow then a clean add keeps V
    cyc(1, 2'b10, 32'h7FFF_FFFF, 0, 0, 0, "R9 load P");
    cyc(1, 2'b00, 32'h0000_0001, 0, 0, 0, "R5 R3 signed overflow");
    cyc(1, 2'b00, 32'h0000_0001, 0, 0, 0, "R5 V sticky");
    // R3 zero result with carry
    cyc(1, 2'b10, 32'h8000_0000, 0, 0, 0, "R9 load P");
    cyc(1, 2'b00, 32'h8000_0000, 0, 0, 0, "R3 R4 zero result");
    // R7 sat_mode: no effect on unsigned add, clamps add with carry
    cyc(1, 2'b10, 32'h7FFF_FFFF, 1, 0, 0, "R9 load P");
    cyc(1, 2'b00, 32'h7FFF_FFFF, 1, 0, 0, "R7 addu ignores sat");
    cyc(1, 2'b11, 32'h7FFF_FFF0, 1, 0, 0, "R9 load ACC");
    cyc(1, 2'b01, 32'h0000_0100, 1, 0, 0, "R7 positive clamp");
    cyc(1, 2'b11, 32'h8000_0010, 1, 0, 0, "R9 load ACC");
    cyc(1, 2'b01, 32'hFFFF_FF00, 1, 0, 0, "R7 negative clamp");
    // R8 repeat count
    cyc(0, 2'b00, 32'h0, 0, 1, 8'd9, "R8 load repeat");
    cyc(0, 2'b00, 32'h1234, 0, 0, 0, "R10 idle hold");
    cyc(1, 2'b00, 32'h0000_0003, 0, 0, 0, "R8 addu clears repeat");
    cyc(1, 2'b00, 32'h0000_0003, 0, 1, 8'd17, "R8 clear beats set");
    cyc(0, 2'b01, 32'hFFFF_FFFF, 1, 0, 0, "R10 idle hold");

    // R6 counter wraps after 64 carries
    ovc_before = int'(ovc_out);
    for (int i = 0; i < 64; i++) begin
      cyc(1, 2'b10, 32'hFFFF_FFFF, i[0], 0, 0, "R9 load P");
      cyc(1, 2'b00, 32'h0000_0001, i[1], 0, 0, "R6 carry count");
    end
    checks++;
    if (int'(ovc_out) != ovc_before) begin
      errors++;
      $display("FAIL R6 wrap: got %0d expected %0d", ovc_out, ovc_before);
    end

    // R2 64-bit chained sums
    for (int k = 0; k < 6; k++) begin
      x = {$urandom(), $urandom()};
      y = {$urandom(), $urandom()};
      if (k == 0) begin x = 64'h0000_0001_FFFF_FFFF; y = 64'h0000_0002_0000_0001; end
      s = x + y;
      cyc(1, 2'b10, x[31:0], 0, 0, 0, "R9 load P");
      cyc(1, 2'b11, x[63:32], 0, 0, 0, "R9 load ACC");
      cyc(1, 2'b00, y[31:0], 0, 0, 0, "R1 low word");
      cyc(1, 2'b01, y[63:32], 0, 0, 0, "R2 high word");
      checks++;
      if ({acc_out, p_out} !== s) begin
        errors++;
        $display("FAIL R2 64-bit sum: got %h expected %h", {acc_out, p_out}, s);
      end
    end

    // mixed traffic with reset in the middle
    for (int j = 0; j < 400; j++) begin
      logic [31:0] r;
      r = $urandom();
      if (j == 200) begin
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_p = 0; m_acc = 0; m_n = 0; m_z = 0; m_c = 0; m_v = 0; m_ovc = 0; m_rpt = 0;
        op_valid = 0; rpt_set = 0;
        @(negedge clk);
        compare("R11 mid-run reset");
      end
      cyc(r[0] | r[1], r[3:2], (r[4] ? 32'hFFFF_FFFF - {28'd0, r[8:5]} : $urandom()),
          r[9], r[10], r[18:11], "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule